// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of an asynchronous parallel flash read bus. Software has already written a program or erase command to the flash. It then starts this poller, which finds out whether the flash has finished the internal operation. It reads the same status location in pairs and compares bit 6 of the two reads. While the flash is busy that bit flips on every read. Once it holds still, the operation is over. The poller then makes one more read to fetch valid array data, returns that data and reports success.

While the bit is still flipping, bit 5 of the second read shows whether the flash has run past its internal time limit. If bit 5 is set, the poller reads one more pair to confirm. If that pair has stopped flipping, the result is success. If it is still flipping, the poller writes the reset command byte to the flash and reports failure. A programmable cap on the number of flipping pairs ends a poll that never settles with a timeout result. After a sector erase, the host can ask the poller to capture bit 3 of the first status read. A high bit 3 means the erase window was already closed, so the last erase command may not have been accepted.

Each bus access holds chip-enable and output-enable (or write-enable) low for a programmable number of cycles. All strobes then go back high for a programmable recovery time before the next access. The address stays fixed for the whole poll.

Top module: `tbp_poller`

## Requirements
- R1: During and after synchronous reset, `fl_ce_n_o`, `fl_oe_n_o` and `fl_we_n_o` are 1, and `fl_dq_oe_o`, `busy_o` and `done_o` are 0.
- R2: Each access holds `fl_ce_n_o` low for exactly `acc_cycles_i` cycles (0 is treated as 1). For a read, `fl_oe_n_o` is low over the same cycles. Between accesses all strobes stay high for at least `rec_cycles_i` cycles (0 is treated as 1). `fl_oe_n_o` and `fl_we_n_o` are never low together. `fl_addr_o` equals the `addr_i` captured at start whenever `fl_ce_n_o` is low.
- R3: If bit 6 of the two reads of a pair is equal, the poller makes exactly one more read and finishes with result 2'b00 (done). `data_o` then holds the byte returned by that final read.
- R4: If bit 6 differs and bit 5 of the pair's second read is 0, the poller starts another pair. Reads are consumed strictly two per pair.
- R5: When the number of flipping pairs with bit 5 equal to 0 reaches `pair_limit_i` (0 is treated as 1), the poll ends with result 2'b01 (timeout). No write is made.
- R6: If a pair flips and bit 5 of its second read is 1, one confirming pair is read. If bit 6 matches across that pair, the poll ends as in R3, with a final read and result 2'b00.
- R7: If the confirming pair still flips, the poller makes one write access of data 8'hF0 with `fl_dq_oe_o` high and `fl_we_n_o` low, then finishes with result 2'b10 (failed).
- R8: When `chk_win_i` is 1 at start, `win_closed_o` reports bit 3 of the first status read. Otherwise it reports 0.
- R9: `busy_o` rises in the cycle after an accepted `start_i`. `done_o` is a single-cycle pulse raised with `busy_o` already low, and there is exactly one pulse per poll. A `start_i` while busy is ignored.
- R10: When a flipping pair shows bit 5 = 1 in the same step that would also reach the pair limit, the confirming pair of R6/R7 takes precedence, and the result is never timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a poll (accepted only when idle) |
| chk_win_i | input | 1 | Capture the erase-window bit of the first read |
| addr_i | input | AW | Status location address |
| acc_cycles_i | input | CW | Strobe-low cycles per access |
| rec_cycles_i | input | CW | Minimum strobe-high cycles between accesses |
| pair_limit_i | input | PW | Maximum flipping pairs before timeout |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 done, 01 timeout, 10 failed |
| win_closed_o | output | 1 | Erase window was closed at first read |
| data_o | output | 8 | Array byte from the final read |
| fl_ce_n_o | output | 1 | Flash chip-enable, active low |
| fl_oe_n_o | output | 1 | Flash output-enable, active low |
| fl_we_n_o | output | 1 | Flash write-enable, active low |
| fl_addr_o | output | AW | Flash address |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_oe_o | output | 1 | Drive enable for write data |
| fl_dq_i | input | 8 | Flash read data |

## Verification
Two decisions can fall on the same read: a pair that still flips with bit 5 set, and the flipping-pair count reaching its limit. A behavioural flash model raises bit 5 from read 1 while the pair limit is 0 or 1, so both conditions meet on the very first pair. The bench then requires a confirmed done or failed result, never a timeout. A sweep over busy length, bit-5 onset and limit predicts each outcome, the exact number of reads and any reset write, all worked out from the pair arithmetic.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    localparam int DQ_W      = 8;
    localparam int TOG_BIT   = 6;
    localparam int LIMIT_BIT = 5;
    localparam int WIN_BIT   = 3;

    localparam logic [DQ_W-1:0] RESET_CMD = 8'hF0;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_TIMEOUT = 2'b01,
        RES_FAIL    = 2'b10
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_RC1,
        ST_RC2,
        ST_FIN,
        ST_RST
    } st_e;

    typedef struct packed {
        logic tog;
        logic toggling;
        logic exceeded;
        logic window;
    } verdict_t;

    function automatic logic bits_differ(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/tbp_bus_phy.sv
module tbp_bus_phy
    import tbp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic            wr_i,
    input  logic [DQ_W-1:0] wdata_i,
    input  logic [CW-1:0]   acc_i,
    input  logic [CW-1:0]   rec_i,
    output logic            ack_o,
    output logic [DQ_W-1:0] rdata_o,
    output logic            ce_n_o,
    output logic            oe_n_o,
    output logic            we_n_o,
    output logic            dq_oe_o,
    output logic [DQ_W-1:0] dq_o,
    input  logic [DQ_W-1:0] dq_i
);

    typedef enum logic [1:0] {P_IDLE, P_ACT, P_REC} ph_e;

    ph_e             ph_q;
    logic [CW-1:0]   cnt_q;
    logic            wr_q;
    logic [DQ_W-1:0] wd_q;
    logic [CW-1:0]   acc_eff;
    logic [CW-1:0]   rec_eff;

    assign acc_eff = (acc_i == '0) ? CW'(1) : acc_i;
    assign rec_eff = (rec_i == '0) ? CW'(1) : rec_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= P_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            wd_q    <= '0;
            ack_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o <= 1'b0;
            case (ph_q)
                P_IDLE: begin
                    if (req_i) begin
                        ph_q  <= P_ACT;
                        cnt_q <= acc_eff - 1'b1;
                        wr_q  <= wr_i;
                        wd_q  <= wdata_i;
                    end
                end
                P_ACT: begin
                    if (cnt_q == '0) begin
                        ph_q  <= P_REC;
                        cnt_q <= rec_eff - 1'b1;
                        ack_o <= 1'b1;
                        if (!wr_q) begin
                            rdata_o <= dq_i;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                P_REC: begin
                    if (cnt_q == '0) begin
                        ph_q <= P_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ph_q <= P_IDLE;
            endcase
        end
    end

    assign ce_n_o  = (ph_q != P_ACT);
    assign oe_n_o  = !((ph_q == P_ACT) && !wr_q);
    assign we_n_o  = !((ph_q == P_ACT) && wr_q);
    assign dq_oe_o = (ph_q == P_ACT) && wr_q;
    assign dq_o    = wd_q;

    // R2: read and write strobes never overlap
    a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n_o && !we_n_o));

    // R2: at least one high cycle after every access
    a_r2_recovery_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n_o) |=> ce_n_o);

    // R2: completion is reported only once the access has ended
    a_r2_ack_after_access: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (ce_n_o && $past(!ce_n_o)));

    // R7: a write access always drives the data bus
    a_r7_write_drives_bus: assert property (@(posedge clk) disable iff (rst)
        !we_n_o |-> dq_oe_o);

endmodule

// File: rtl/tbp_judge.sv
module tbp_judge
    import tbp_pkg::*;
(
    input  logic     ref_tog_i,
    input  logic     tog_bit_i,
    input  logic     limit_bit_i,
    input  logic     win_bit_i,
    output verdict_t v_o
);

    always_comb begin
        v_o.tog      = tog_bit_i;
        v_o.toggling = bits_differ(ref_tog_i, tog_bit_i);
        v_o.exceeded = limit_bit_i;
        v_o.window   = win_bit_i;
    end

endmodule

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
    import tbp_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            chk_win_i,
    input  logic [PW-1:0]   limit_i,
    output logic            busy_o,
    output logic            done_o,
    output res_e            result_o,
    output logic            win_o,
    output logic [DQ_W-1:0] data_o,
    output logic            req_o,
    output logic            wr_o,
    output logic [DQ_W-1:0] wdata_o,
    output logic            ref_tog_o,
    input  logic            ack_i,
    input  logic [DQ_W-1:0] rdata_i,
    input  verdict_t        v_i
);

    st_e           st_q;
    logic [PW-1:0] pairs_q;
    logic [PW-1:0] lim_q;
    logic [PW-1:0] lim_eff;
    logic          tog_q;
    logic          first_q;
    logic          chk_q;

    assign lim_eff   = (limit_i == '0) ? PW'(1) : limit_i;
    assign busy_o    = (st_q != ST_IDLE);
    assign req_o     = busy_o;
    assign wr_o      = (st_q == ST_RST);
    assign wdata_o   = RESET_CMD;
    assign ref_tog_o = tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            pairs_q  <= '0;
            lim_q    <= PW'(1);
            tog_q    <= 1'b0;
            first_q  <= 1'b0;
            chk_q    <= 1'b0;
            done_o   <= 1'b0;
            result_o <= RES_OK;
            win_o    <= 1'b0;
            data_o   <= '0;
        end else begin
            done_o <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q    <= ST_RD1;
                        pairs_q <= '0;
                        lim_q   <= lim_eff;
                        first_q <= 1'b1;
                        chk_q   <= chk_win_i;
                        win_o   <= 1'b0;
                    end
                end
                ST_RD1: begin
                    if (ack_i) begin
                        tog_q   <= v_i.tog;
                        first_q <= 1'b0;
                        if (first_q && chk_q) begin
                            win_o <= v_i.window;
                        end
                        st_q <= ST_RD2;
                    end
                end
                ST_RD2: begin
                    if (ack_i) begin
                        if (!v_i.toggling) begin
                            st_q <= ST_FIN;
                        end else if (v_i.exceeded) begin
                            st_q <= ST_RC1;
                        end else if ((pairs_q + 1'b1) == lim_q) begin
                            st_q     <= ST_IDLE;
                            done_o   <= 1'b1;
                            result_o <= RES_TIMEOUT;
                        end else begin
                            pairs_q <= pairs_q + 1'b1;
                            st_q    <= ST_RD1;
                        end
                    end
                end
                ST_RC1: begin
                    if (ack_i) begin
                        tog_q <= v_i.tog;
                        st_q  <= ST_RC2;
                    end
                end
                ST_RC2: begin
                    if (ack_i) begin
                        st_q <= v_i.toggling ? ST_RST : ST_FIN;
                    end
                end
                ST_FIN: begin
                    if (ack_i) begin
                        data_o   <= rdata_i;
                        st_q     <= ST_IDLE;
                        done_o   <= 1'b1;
                        result_o <= RES_OK;
                    end
                end
                ST_RST: begin
                    if (ack_i) begin
                        st_q     <= ST_IDLE;
                        done_o   <= 1'b1;
                        result_o <= RES_FAIL;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R9: completion is a single pulse and the poller is idle by then
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R5: the flipping-pair count never reaches the limit while busy
    a_r5_pairs_bound: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (pairs_q < lim_q));

    // R7: a failed result is always preceded by the reset write
    a_r7_fail_after_write: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == RES_FAIL) |-> $past(wr_o));

    // R3: a success is always preceded by the final array read
    a_r3_ok_after_final_read: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == RES_OK) |-> $past(st_q == ST_FIN));

    // R8: the window flag stays clear when it was not requested
    a_r8_window_off: assert property (@(posedge clk) disable iff (rst)
        (done_o && !chk_q) |-> !win_o);

endmodule

// File: rtl/tbp_poller.sv
module tbp_poller
    import tbp_pkg::*;
#(
    parameter int AW = 21,
    parameter int CW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          chk_win_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] acc_cycles_i,
    input  logic [CW-1:0] rec_cycles_i,
    input  logic [PW-1:0] pair_limit_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    result_o,
    output logic          win_closed_o,
    output logic [7:0]    data_o,
    output logic          fl_ce_n_o,
    output logic          fl_oe_n_o,
    output logic          fl_we_n_o,
    output logic [AW-1:0] fl_addr_o,
    output logic [7:0]    fl_dq_o,
    output logic          fl_dq_oe_o,
    input  logic [7:0]    fl_dq_i
);

    logic            req_w;
    logic            wr_w;
    logic [DQ_W-1:0] wdata_w;
    logic            ack_w;
    logic [DQ_W-1:0] rdata_w;
    logic            ref_tog_w;
    verdict_t        verdict_w;
    res_e            res_w;
    logic [AW-1:0]   addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (start_i && !busy_o) begin
            addr_q <= addr_i;
        end
    end

    assign fl_addr_o = addr_q;
    assign result_o  = res_w;

    tbp_bus_phy #(.CW(CW)) u_phy (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_w),
        .wr_i    (wr_w),
        .wdata_i (wdata_w),
        .acc_i   (acc_cycles_i),
        .rec_i   (rec_cycles_i),
        .ack_o   (ack_w),
        .rdata_o (rdata_w),
        .ce_n_o  (fl_ce_n_o),
        .oe_n_o  (fl_oe_n_o),
        .we_n_o  (fl_we_n_o),
        .dq_oe_o (fl_dq_oe_o),
        .dq_o    (fl_dq_o),
        .dq_i    (fl_dq_i)
    );

    tbp_judge u_judge (
        .ref_tog_i   (ref_tog_w),
        .tog_bit_i   (rdata_w[TOG_BIT]),
        .limit_bit_i (rdata_w[LIMIT_BIT]),
        .win_bit_i   (rdata_w[WIN_BIT]),
        .v_o         (verdict_w)
    );

    tbp_ctrl #(.PW(PW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .chk_win_i (chk_win_i),
        .limit_i   (pair_limit_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (res_w),
        .win_o     (win_closed_o),
        .data_o    (data_o),
        .req_o     (req_w),
        .wr_o      (wr_w),
        .wdata_o   (wdata_w),
        .ref_tog_o (ref_tog_w),
        .ack_i     (ack_w),
        .rdata_i   (rdata_w),
        .v_i       (verdict_w)
    );

    // R2: the status address holds for the whole poll
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(fl_addr_o));

endmodule

// File: tb/tbp_poller_test.sv
`timescale 1ns/1ps
module tbp_poller_test;

    localparam int AW = 21;
    localparam int CW = 8;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic          chk_win_i;
    logic [AW-1:0] addr_i;
    logic [CW-1:0] acc_cycles_i;
    logic [CW-1:0] rec_cycles_i;
    logic [PW-1:0] pair_limit_i;
    logic          busy_o;
    logic          done_o;
    logic [1:0]    result_o;
    logic          win_closed_o;
    logic [7:0]    data_o;
    logic          fl_ce_n;
    logic          fl_oe_n;
    logic          fl_we_n;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_o;
    logic          fl_dq_oe;
    logic [7:0]    fl_dq_i;

    always #2.5 clk = ~clk;

    tbp_poller #(.AW(AW), .CW(CW), .PW(PW)) uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .chk_win_i    (chk_win_i),
        .addr_i       (addr_i),
        .acc_cycles_i (acc_cycles_i),
        .rec_cycles_i (rec_cycles_i),
        .pair_limit_i (pair_limit_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .result_o     (result_o),
        .win_closed_o (win_closed_o),
        .data_o       (data_o),
        .fl_ce_n_o    (fl_ce_n),
        .fl_oe_n_o    (fl_oe_n),
        .fl_we_n_o    (fl_we_n),
        .fl_addr_o    (fl_addr),
        .fl_dq_o      (fl_dq_o),
        .fl_dq_oe_o   (fl_dq_oe),
        .fl_dq_i      (fl_dq_i)
    );

    int checks = 0;
    int errors = 0;

    // behavioural flash: bit 6 flips per read while busy, bit 5 from read f_at on
    int         busy_left = 0;
    int         f_at = 1000;
    int         rd_idx = 0;
    int         wr_cnt = 0;
    logic       tog = 1'b0;
    logic [7:0] arr = 8'h0F;
    logic       win = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_oe = 1'b0;

    assign fl_dq_i = (busy_left > 0) ?
        {~arr[7], tog, (rd_idx >= f_at), 1'b0, win, 3'b000} : arr;

    always @(posedge fl_oe_n) begin
        if (busy_left > 0) begin
            tog = ~tog;
            busy_left--;
        end
        rd_idx++;
    end

    always @(posedge fl_we_n) begin
        wr_cnt++;
        busy_left = 0;
    end

    // bus timing monitor
    int            lowrun = 0;
    int            highrun = 1000;
    int            tviol = 0;
    int            cfg_acc = 1;
    int            cfg_rec = 1;
    logic [AW-1:0] exp_addr = '0;
    int            done_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!fl_we_n) begin
                wr_data = fl_dq_o;
                wr_oe   = fl_dq_oe;
            end
            if (!fl_oe_n && !fl_we_n) tviol++;
            if (!fl_ce_n && fl_addr !== exp_addr) tviol++;
            if (!fl_oe_n || !fl_we_n) begin
                if (fl_ce_n) tviol++;
                if (lowrun == 0 && highrun < cfg_rec) tviol++;
                lowrun++;
                highrun = 0;
            end else begin
                if (lowrun != 0 && lowrun != cfg_acc) tviol++;
                lowrun = 0;
                highrun++;
            end
            if (done_o) done_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected outcome from pair arithmetic: 0 done, 1 timeout, 2 failed
    function automatic void predict(input int b, input int f, input int l,
                                    output int res, output int reads, output int wr,
                                    output bit rechecked);
        int  i = 0;
        int  cnt = 0;
        int  lim = (l == 0) ? 1 : l;
        bit  fin = 1'b0;
        res = 0; reads = 0; wr = 0; rechecked = 1'b0;
        while (!fin) begin
            if (!(i + 1 < b)) begin
                res = 0; reads = i + 3; fin = 1'b1;
            end else if (i + 1 >= f) begin
                rechecked = 1'b1;
                if (i + 3 < b) begin
                    res = 2; reads = i + 4; wr = 1;
                end else begin
                    res = 0; reads = i + 5;
                end
                fin = 1'b1;
            end else begin
                cnt++;
                if (cnt == lim) begin
                    res = 1; reads = i + 2; fin = 1'b1;
                end else begin
                    i += 2;
                end
            end
        end
    endfunction

    task automatic run(input int b, input int f, input int l, input bit cw,
                       input logic [7:0] a, input bit w, input int acc, input int rec,
                       input logic [AW-1:0] ad);
        int   er;
        int   ereads;
        int   ewr;
        bit   rc;
        int   n;
        logic ewin;
        predict(b, f, l, er, ereads, ewr, rc);
        ewin = cw ? ((b > 0) ? w : a[3]) : 1'b0;
        @(negedge clk);
        busy_left = b; f_at = f; rd_idx = 0; wr_cnt = 0; tog = 1'b0;
        arr = a; win = w; done_cnt = 0; tviol = 0;
        cfg_acc = acc; cfg_rec = rec; exp_addr = ad;
        acc_cycles_i = CW'(acc); rec_cycles_i = CW'(rec); pair_limit_i = PW'(l);
        chk_win_i = cw; addr_i = ad; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        addr_i  = ~ad;
        check("R9 busy after start", busy_o, 1);
        repeat (3) @(negedge clk);
        start_i = 1'b1;            // R9: ignored while busy
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check("R9 done reached", done_o, 1);
        check("R9 idle at done", busy_o, 0);
        if (er == 1)      check("R5 timeout result", result_o, 1);
        else if (er == 2) check("R7 failed result", result_o, 2);
        else if (rc)      check("R6 confirmed done result", result_o, 0);
        else              check("R3 done result", result_o, 0);
        if (er == 0) check("R3 final array data", data_o, a);
        check("R4 read count", rd_idx, ereads);
        check("R7 reset write count", wr_cnt, ewr);
        if (ewr == 1) begin
            check("R7 reset write data", wr_data, 8'hF0);
            check("R7 write drive enable", wr_oe, 1);
        end
        check("R8 window flag", win_closed_o, ewin);
        if (f <= 1 && b >= 2 && l <= 1)
            check("R10 confirm precedes watchdog", (result_o == 2'b01), 0);
        repeat (rec + 3) @(negedge clk);
        check("R9 one done pulse", done_cnt, 1);
        check("R2 bus timing and address", tviol, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int fs[3];
        int ls[4];
        int k;
        fs[0] = 1; fs[1] = 4; fs[2] = 1000;
        ls[0] = 1; ls[1] = 2; ls[2] = 3; ls[3] = 0;
        rst = 1'b1; start_i = 1'b0; chk_win_i = 1'b0; addr_i = '0;
        acc_cycles_i = 8'd1; rec_cycles_i = 8'd1; pair_limit_i = 8'd1;
        repeat (4) @(negedge clk);
        check("R1 ce_n in reset", fl_ce_n, 1);
        check("R1 oe_n in reset", fl_oe_n, 1);
        check("R1 we_n in reset", fl_we_n, 1);
        check("R1 dq_oe in reset", fl_dq_oe, 0);
        check("R1 busy in reset", busy_o, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", done_o, 0);
        check("R1 busy after reset", busy_o, 0);
        check("R1 ce_n after reset", fl_ce_n, 1);
        k = 0;
        for (int b = 0; b < 10; b++) begin
            for (int fi = 0; fi < 3; fi++) begin
                for (int li = 0; li < 4; li++) begin
                    run(b, fs[fi], ls[li], k[0], (k[1] ? 8'h9A : 8'h0F), k[2],
                        1 + (k % 3), 1 + ((k / 3) % 2), AW'(21'h1234 + k));
                    k++;
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule